// File: doc/BRIEF.md
# Posted Memory Write Packet Builder

This block converts a single-word write command into a posted memory write transaction packet. The packet goes out one 32-bit word per beat on a valid/ready stream, with start and end markers. A command carries a 64-bit address, one 32-bit data word and a traffic class. The requester identity comes from a static input. The header is three words long when the address fits in 32 bits and four words long otherwise. Exactly one data word follows the header.

The same path raises message-signalled interrupts. An interrupt request sends an ordinary posted write whose address and data come from two configuration inputs that host software programs at start-up. While a packet is being streamed, no new request is taken. Nothing is tracked once a packet has left, because the write is posted and no completion ever comes back.

A bus-master enable input gates everything. While it is low, requests are still accepted at the handshake but are discarded, and a one-cycle error pulse reports each discarded request.

Top module: `mwr_packet_builder`

## Requirements
- R1: When address bits [63:32] are all zero, the packet is 4 words long. Word 0 bits [31:24] are 0x40. Word 2 is the address bits [31:2] with bits [1:0] forced to zero. Word 3 is the data word.
- R2: When any of address bits [63:32] is set, the packet is 5 words long. Word 0 bits [31:24] are 0x60. Word 2 is address bits [63:32]. Word 3 is address bits [31:2] with bits [1:0] zero. Word 4 is the data word.
- R3: In word 0, bits [22:20] hold the traffic class and bits [9:0] hold a length of 1. Bit 23 and bits [19:10] are zero.
- R4: In word 1, bits [31:16] hold the requester ID and bits [15:8] hold a tag. Bits [7:4] are 0 and bits [3:0] are 0xF. The tag is 0 after reset and rises by one, modulo 256, for each packet emitted.
- R5: `pkt_sop` is high only on word 0 and `pkt_eop` is high only on the data word, which is the final word of the packet.
- R6: While `pkt_valid` is high and `pkt_ready` is low, `pkt_word`, `pkt_sop`, `pkt_eop` and `pkt_valid` hold their values into the next cycle.
- R7: `cmd_ready` and `irq_ready` are low from the cycle after a request is accepted until the cycle after the final word is taken. A packet's first word appears in the cycle after its request is accepted.
- R8: An interrupt request sends a packet built from `irq_addr` and `irq_data` with traffic class 0, using the same header size rule. When both requests are valid, the interrupt is taken first and `cmd_ready` stays low while `irq_valid` is high.
- R9: While `bus_master_en` is low, an accepted request produces no packet and does not advance the tag. `drop_err` is high for exactly the cycle after that acceptance.
- R10: During and right after reset, `pkt_valid` and `drop_err` are low and `irq_ready` is high. `cmd_ready` is high when `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_master_en | input | 1 | Permission to issue requests |
| requester_id | input | 16 | Identity placed in header word 1 |
| cmd_valid | input | 1 | Write command present |
| cmd_ready | output | 1 | Write command accepted this cycle when valid |
| cmd_addr | input | 64 | Write byte address |
| cmd_data | input | 32 | Write data word |
| cmd_tc | input | 3 | Write traffic class |
| irq_valid | input | 1 | Interrupt request present |
| irq_ready | output | 1 | Interrupt request accepted this cycle when valid |
| irq_addr | input | 64 | Host-programmed interrupt address |
| irq_data | input | 32 | Host-programmed interrupt data |
| pkt_valid | output | 1 | Output word present |
| pkt_ready | input | 1 | Downstream takes the word |
| pkt_word | output | 32 | Output word |
| pkt_sop | output | 1 | First word of packet |
| pkt_eop | output | 1 | Final word of packet |
| drop_err | output | 1 | Request discarded because bus mastering is off |

## Verification
Properties are checked on every cycle for several behaviours:
- Output words stay stable under back-pressure.
- Start and end markers never coincide, and the stream goes idle once an end word is taken.
- Both readies stay low while a packet is in flight.
- Every start word carries a legal format byte and a length of one.
- A request discarded for lack of bus mastering raises the error pulse and starts no packet.

Some behaviours only the bench scenarios can show:
- The 4 GB boundary choice between header sizes.
- The address word order.
- Tag wrap-around after 256 packets.
- Interrupt priority over a waiting command.
- The absence of any output and of any tag advance for discarded requests.

The bench compares all of these against a behavioural model on every clock.

// File: rtl/mwr_pkg.sv
// Package: shared widths, format codes and the request record for the
// posted memory write packet builder. Assumes a 32-bit stream word.
package mwr_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 64;
    localparam int TC_W      = 3;
    localparam int ID_W      = 16;
    localparam int TAG_W     = 8;
    localparam int MAX_WORDS = 5;
    localparam int IDX_W     = $clog2(MAX_WORDS);

    localparam logic [7:0] FT_WR_SHORT = 8'h40;
    localparam logic [7:0] FT_WR_LONG  = 8'h60;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [TC_W-1:0]   tc;
    } wr_req_t;
endpackage

// File: rtl/mwr_req_select.sv
// Request selector: picks an interrupt request over a write command and
// accepts either only while the output path is idle. Accepted requests
// either load a packet (bus mastering on) or are discarded with a
// one-cycle error pulse. Assumes path_idle drops the cycle after a load.
module mwr_req_select
    import mwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_master_en,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic [TC_W-1:0]   cmd_tc,
    input  logic              irq_valid,
    input  logic [ADDR_W-1:0] irq_addr,
    input  logic [WORD_W-1:0] irq_data,
    input  logic              path_idle,
    output logic              cmd_ready,
    output logic              irq_ready,
    output logic              load,
    output wr_req_t           sel_req,
    output logic              drop_err
);
    logic irq_take;
    logic cmd_take;
    logic any_take;

    // Handshake: interrupt wins; command waits while an interrupt is pending
    always_comb begin
        irq_ready = path_idle;
        cmd_ready = path_idle && !irq_valid;
        irq_take  = irq_valid && irq_ready;
        cmd_take  = cmd_valid && cmd_ready;
        any_take  = irq_take || cmd_take;
        load      = any_take && bus_master_en;
    end

    // Source mux: interrupt writes always use traffic class 0
    always_comb begin
        if (irq_take) begin
            sel_req.addr = irq_addr;
            sel_req.data = irq_data;
            sel_req.tc   = '0;
        end else begin
            sel_req.addr = cmd_addr;
            sel_req.data = cmd_data;
            sel_req.tc   = cmd_tc;
        end
    end

    // Error pulse for each request discarded while bus mastering is off
    always_ff @(posedge clk) begin
        if (!rst_n) drop_err <= 1'b0;
        else        drop_err <= any_take && !bus_master_en;
    end

    // R9
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !bus_master_en) |=> (drop_err && path_idle));

    // R9
    drop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_err && !$past(irq_valid)) |-> $past(cmd_valid && !bus_master_en));
endmodule

// File: rtl/mwr_hdr_build.sv
// Header builder: lays out the header and data words of one posted write
// for the selected request, chooses short or long addressing from the
// upper address half, and keeps the per-packet tag counter.
// Assumes load is high for one cycle per emitted packet.
module mwr_hdr_build
    import mwr_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  wr_req_t                            req,
    input  logic [ID_W-1:0]                    requester_id,
    output logic [MAX_WORDS-1:0][WORD_W-1:0]   words,
    output logic [IDX_W-1:0]                   last_idx
);
    logic [TAG_W-1:0]  tag_q;
    logic              long_fmt;
    logic [WORD_W-1:0] low_addr;
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;

    // Tag counter: advances once per packet actually loaded
    always_ff @(posedge clk) begin
        if (!rst_n)    tag_q <= '0;
        else if (load) tag_q <= tag_q + 1'b1;
    end

    // Field packing for the two fixed header words
    always_comb begin
        long_fmt = |req.addr[ADDR_W-1:WORD_W];
        low_addr = req.addr[WORD_W-1:0] & 32'hFFFF_FFFC;
        w0 = {(long_fmt ? FT_WR_LONG : FT_WR_SHORT), 1'b0, req.tc, 10'd0, 10'd1};
        w1 = {requester_id, tag_q, 4'h0, 4'hF};
    end

    // Word placement: address words, then the single data word last
    always_comb begin
        words[0] = w0;
        words[1] = w1;
        if (long_fmt) begin
            words[2] = req.addr[ADDR_W-1:WORD_W];
            words[3] = low_addr;
            words[4] = req.data;
            last_idx = IDX_W'(MAX_WORDS - 1);
        end else begin
            words[2] = low_addr;
            words[3] = req.data;
            words[4] = '0;
            last_idx = IDX_W'(MAX_WORDS - 2);
        end
    end
endmodule

// File: rtl/mwr_beat_ser.sv
// Beat serializer: captures a whole packet on load and presents it one
// word per beat with start/end markers, holding each word under
// back-pressure. Assumes load only arrives while path_idle is high.
module mwr_beat_ser
    import mwr_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [MAX_WORDS-1:0][WORD_W-1:0]   words,
    input  logic [IDX_W-1:0]                   last_idx,
    input  logic                               pkt_ready,
    output logic                               pkt_valid,
    output logic [WORD_W-1:0]                  pkt_word,
    output logic                               pkt_sop,
    output logic                               pkt_eop,
    output logic                               path_idle
);
    logic [MAX_WORDS-1:0][WORD_W-1:0] lane_q;
    logic                             busy_q;
    logic [IDX_W-1:0]                 idx_q;
    logic [IDX_W-1:0]                 last_q;
    logic                             beat_done;

    // Packet storage: one register lane per word position
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)    lane_q[g] <= '0;
            else if (load) lane_q[g] <= words[g];
        end
    end

    assign beat_done = busy_q && pkt_ready;

    // Beat sequencing: start at word 0, stop after the final word is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= last_idx;
        end else if (beat_done) begin
            if (idx_q == last_q) busy_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    // Output view of the current beat
    always_comb begin
        pkt_valid = busy_q;
        pkt_word  = lane_q[idx_q];
        pkt_sop   = busy_q && (idx_q == '0);
        pkt_eop   = busy_q && (idx_q == last_q);
        path_idle = !busy_q;
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_word)
                                       && $stable(pkt_sop) && $stable(pkt_eop)));

    // R5
    marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !(pkt_sop && pkt_eop));

    // R5
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_eop) |=> !pkt_valid);
endmodule

// File: rtl/mwr_packet_builder.sv
// Top: posted memory write packet builder. Accepts a write command or an
// interrupt request, builds a 3- or 4-word header plus one data word and
// streams it out. Assumes bus_master_en and requester_id are quasi-static.
module mwr_packet_builder
    import mwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_master_en,
    input  logic [15:0]       requester_id,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [63:0]       cmd_addr,
    input  logic [31:0]       cmd_data,
    input  logic [2:0]        cmd_tc,
    input  logic              irq_valid,
    output logic              irq_ready,
    input  logic [63:0]       irq_addr,
    input  logic [31:0]       irq_data,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [31:0]       pkt_word,
    output logic              pkt_sop,
    output logic              pkt_eop,
    output logic              drop_err
);
    logic                             path_idle;
    logic                             load;
    wr_req_t                          sel_req;
    logic [MAX_WORDS-1:0][WORD_W-1:0] words;
    logic [IDX_W-1:0]                 last_idx;

    mwr_req_select u_select (
        .clk(clk), .rst_n(rst_n), .bus_master_en(bus_master_en),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_tc(cmd_tc),
        .irq_valid(irq_valid), .irq_addr(irq_addr), .irq_data(irq_data),
        .path_idle(path_idle), .cmd_ready(cmd_ready), .irq_ready(irq_ready),
        .load(load), .sel_req(sel_req), .drop_err(drop_err)
    );

    mwr_hdr_build u_hdr (
        .clk(clk), .rst_n(rst_n), .load(load), .req(sel_req),
        .requester_id(requester_id), .words(words), .last_idx(last_idx)
    );

    mwr_beat_ser u_ser (
        .clk(clk), .rst_n(rst_n), .load(load), .words(words), .last_idx(last_idx),
        .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
        .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .path_idle(path_idle)
    );

    // R7
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (!cmd_ready && !irq_ready));

    // R3
    start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_sop) |-> ((pkt_word[9:0] == 10'd1)
            && (pkt_word[31:24] == FT_WR_SHORT || pkt_word[31:24] == FT_WR_LONG)));

    // R9
    start_needs_bme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(bus_master_en));
endmodule

// File: tb/test_mwr_packet_builder.sv
// Bench: behavioural reference model (queue of expected beats) compared
// against the design on every falling clock edge.
module test_mwr_packet_builder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_master_en = 1'b1;
    logic [15:0] requester_id = 16'hBEEF;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [2:0]  cmd_tc = '0;
    logic        irq_valid = 1'b0;
    logic        irq_ready;
    logic [63:0] irq_addr = 64'h0000_0000_FEE0_1004;
    logic [31:0] irq_data = 32'h0000_4021;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [31:0] pkt_word;
    logic        pkt_sop;
    logic        pkt_eop;
    logic        drop_err;

    always #10 clk = ~clk;

    mwr_packet_builder i_mwr_packet_builder (
        .clk(clk), .rst_n(rst_n), .bus_master_en(bus_master_en), .requester_id(requester_id),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_tc(cmd_tc), .irq_valid(irq_valid), .irq_ready(irq_ready),
        .irq_addr(irq_addr), .irq_data(irq_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_word(pkt_word), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .drop_err(drop_err)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    int rmode = 0;
    int rcnt = 0;

    typedef struct {
        logic [31:0] w;
        bit          sop;
        bit          eop;
        string       rq;
    } beat_t;
    beat_t q[$];

    int          tag_m = 0;
    bit          drop_now = 1'b0;
    bit          p_xfer = 1'b0, p_acc = 1'b0, p_irq = 1'b0, p_bme = 1'b0, p_stall = 1'b0;
    logic [63:0] p_addr;
    logic [31:0] p_data, p_word;
    logic [2:0]  p_tc;
    logic [15:0] p_id;
    bit          p_sop, p_eop;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic void push_beat(logic [31:0] w, bit s, bit e, string rq);
        beat_t b;
        b.w = w; b.sop = s; b.eop = e; b.rq = rq;
        q.push_back(b);
    endfunction

    // Expected packet from the requirement text (R1, R2, R3, R4, R5)
    function automatic void push_pkt(logic [63:0] a, logic [31:0] d, logic [2:0] tc,
                                     logic [15:0] id, logic [7:0] tg, string dlab);
        bit lng = (a[63:32] != 32'd0);
        logic [31:0] lo = {a[31:2], 2'b00};
        push_beat({(lng ? 8'h60 : 8'h40), 1'b0, tc, 10'd0, 10'd1}, 1, 0, "R3");
        push_beat({id, tg, 4'h0, 4'hF}, 0, 0, "R4");
        if (lng) begin
            push_beat(a[63:32], 0, 0, "R2");
            push_beat(lo, 0, 0, "R2");
        end else begin
            push_beat(lo, 0, 0, "R1");
        end
        push_beat(d, 0, 1, dlab);
    endfunction

    // Downstream ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #3;
        rcnt++;
        pkt_ready = (rmode == 0) ? 1'b1 : ((rcnt % 3 != 0) && (rcnt % 7 != 2));
    end

    // Reference model step and comparison on every falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete();
            tag_m = 0;
            drop_now = 1'b0;
            p_xfer = 0; p_acc = 0; p_stall = 0;
        end else begin
            if (p_xfer && q.size() > 0) void'(q.pop_front());
            drop_now = 1'b0;
            if (p_acc) begin
                if (p_bme) begin
                    push_pkt(p_addr, p_data, p_tc, p_id, tag_m[7:0], p_irq ? "R8" : "R5");
                    tag_m = (tag_m + 1) % 256;
                end else begin
                    drop_now = 1'b1;
                end
            end
            if (p_stall) begin
                check(pkt_word == p_word && pkt_sop == p_sop && pkt_eop == p_eop && pkt_valid,
                      "R6", "held beat", {31'd0, pkt_valid, pkt_word}, {32'd1, p_word});
            end
            check(pkt_valid == (q.size() != 0), "R7", "pkt_valid",
                  64'(pkt_valid), 64'(q.size() != 0));
            if (pkt_valid && q.size() != 0) begin
                check(pkt_word == q[0].w, q[0].rq, "pkt_word", 64'(pkt_word), 64'(q[0].w));
                check(pkt_sop == q[0].sop && pkt_eop == q[0].eop, "R5", "sop/eop",
                      {62'd0, pkt_sop, pkt_eop}, {62'd0, q[0].sop, q[0].eop});
            end
            check(cmd_ready == (q.size() == 0 && !irq_valid), irq_valid ? "R8" : "R7",
                  "cmd_ready", 64'(cmd_ready), 64'(q.size() == 0 && !irq_valid));
            check(irq_ready == (q.size() == 0), "R7", "irq_ready",
                  64'(irq_ready), 64'(q.size() == 0));
            check(drop_err == drop_now, "R9", "drop_err", 64'(drop_err), 64'(drop_now));

            p_xfer  = pkt_valid && pkt_ready;
            p_stall = pkt_valid && !pkt_ready;
            p_word  = pkt_word; p_sop = pkt_sop; p_eop = pkt_eop;
            p_irq   = irq_valid && irq_ready;
            p_acc   = p_irq || (cmd_valid && cmd_ready);
            p_bme   = bus_master_en;
            p_id    = requester_id;
            p_addr  = p_irq ? irq_addr : cmd_addr;
            p_data  = p_irq ? irq_data : cmd_data;
            p_tc    = p_irq ? 3'd0 : cmd_tc;
        end
    end

    task automatic send_cmd(input logic [63:0] a, input logic [31:0] d, input logic [2:0] tc);
        @(posedge clk); #3;
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; cmd_tc = tc;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #3;
        cmd_valid = 1'b0;
    endtask

    task automatic send_irq();
        @(posedge clk); #3;
        irq_valid = 1'b1;
        do @(negedge clk); while (!irq_ready);
        @(posedge clk); #3;
        irq_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (q.size() != 0 || pkt_valid);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(20 * 200000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R10: reset state while reset is held
        repeat (3) @(negedge clk);
        check(!pkt_valid, "R10", "pkt_valid in reset", 64'(pkt_valid), 64'd0);
        check(!drop_err, "R10", "drop_err in reset", 64'(drop_err), 64'd0);
        check(cmd_ready && irq_ready, "R10", "readies in reset",
              {62'd0, cmd_ready, irq_ready}, 64'd3);
        @(posedge clk); #3; rst_n = 1'b1;
        @(negedge clk);
        check(!pkt_valid && cmd_ready, "R10", "after reset",
              {62'd0, pkt_valid, cmd_ready}, 64'd1);

        // R1: short header, low address bits masked
        send_cmd(64'h0000_0000_1234_567B, 32'hA5A5_0001, 3'd2);
        drain();
        // R2: long header
        send_cmd(64'h0000_0001_8000_0004, 32'hA5A5_0002, 3'd7);
        drain();
        // R1 and R2 at the 4 GB boundary, sent back to back (R7)
        send_cmd(64'h0000_0000_FFFF_FFFF, 32'h1111_2222, 3'd1);
        send_cmd(64'h0000_0001_0000_0000, 32'h3333_4444, 3'd5);
        send_cmd(64'hFFFF_FFFF_FFFF_FFFC, 32'h5555_6666, 3'd3);
        drain();

        // R6: back-pressure pattern on both formats
        rmode = 1;
        for (int i = 0; i < 6; i++)
            send_cmd({(i % 2 == 0) ? 32'd0 : 32'h0000_00A0 + 32'(i), 32'h1000_0000 + 32'(i * 4)},
                     32'hC0DE_0000 + 32'(i), 3'(i));
        send_irq();
        drain();
        rmode = 0;

        // R8: interrupt and command raised together, interrupt first
        @(posedge clk); #3;
        irq_valid = 1'b1;
        cmd_valid = 1'b1; cmd_addr = 64'h0000_0000_0000_2000; cmd_data = 32'h7777_8888; cmd_tc = 3'd4;
        do @(negedge clk); while (!irq_ready);
        @(posedge clk); #3; irq_valid = 1'b0;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #3; cmd_valid = 1'b0;
        drain();
        // R8: long interrupt address
        irq_addr = 64'h0000_0010_FEE0_0000;
        send_irq();
        drain();

        // R9: bus mastering off, requests discarded and tag unchanged
        @(posedge clk); #3; bus_master_en = 1'b0;
        send_cmd(64'h0000_0000_0000_4000, 32'hDEAD_0001, 3'd0);
        send_irq();
        send_cmd(64'h0000_0002_0000_4000, 32'hDEAD_0002, 3'd0);
        drain();
        @(posedge clk); #3; bus_master_en = 1'b1;
        send_cmd(64'h0000_0000_0000_5000, 32'hFEED_0001, 3'd6);
        drain();

        // R4: tag wrap-around over more than 256 packets
        for (int i = 0; i < 260; i++)
            send_cmd(64'(32'h0001_0000 + 32'(i * 4)), 32'(i), 3'(i));
        drain();

        done = 1'b1;
        finish_run();
    end
endmodule